// File: doc/BRIEF.md
# Four-Channel Interleaving TDM Multiplexer

This block joins the system-side serial streams of four framer channels into one high-rate single-rail stream, and splits an incoming single-rail stream back into four per-channel bits. All channels share one system clock, where each clock cycle is one aggregate bit period, and one frame-sync pulse. A free-running position counter restarts on that pulse. The counter value gives the phase slot that owns the current bit.

Each channel slice holds a 3-bit phase index. On transmit, a slice passes its channel bit only in its own slot and drives zero otherwise. The four slice outputs are ORed and registered onto the line. On receive, a slice captures the line bit only in its own slot. Ordering is either bit-interleaved or byte-interleaved. A configuration checker rejects byte ordering at the two non-power-of-two rates and rejects shared phase indices. A rejected setup silences the block.

Top module: `tdm_quad_mux`

## Requirements
- R1: While rst_ni is low, mux_tx_o, rx_data_o and rx_vld_o are all zero.
- R2: Multiplexing runs only while cfg_i[7] is 1. With cfg_i[7] at 0, mux_tx_o stays 0 and no rx_vld_o bit is raised. The other cfg_i bits have no effect.
- R3: A cycle with fsync_i high is bit position 0. Each later cycle advances the position by one, wrapping modulo 32. After reset, the first cycle without sync is position 0.
- R4: When byte_mode_i is 0, the active phase slot is the position modulo 4.
- R5: When byte_mode_i is 1, the active phase slot is (position / 8) modulo 4, so each channel owns 8 consecutive bits.
- R6: In each cycle, the slice whose phase index equals the active slot passes its tx_ch_i bit. All other slices give 0, and the OR of the slices appears on mux_tx_o one clock later.
- R7: The phase index of channel c is phase_idx_i[3c+2:3c]. Codes 0 to 3 select slots 0 to 3. Codes 4 to 7 never match, so that channel neither transmits nor receives.
- R8: rate_sel_i encodes 0=16.384, 1=8.192, 2=12.352 and 3=6.176 Mbit/s. Byte mode with rate code 2 or 3 raises config_error_o combinationally. Bit mode is legal at every rate.
- R9: Two channels with the same phase index raise config_error_o combinationally.
- R10: While config_error_o is high, the transmit OR input is forced to 0 and no receive capture occurs.
- R11: In a channel's active slot, the mux_rx_i bit is loaded into rx_data_o[c] and rx_vld_o[c] pulses for one cycle, both one clock later. At other times rx_data_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared system clock, one cycle per aggregate bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Configuration byte; bit 7 enables multiplexing |
| rate_sel_i | input | 2 | Aggregate rate code |
| byte_mode_i | input | 1 | 1 selects byte interleaving, 0 selects bit interleaving |
| phase_idx_i | input | 12 | Four 3-bit phase indices, channel 0 in the low bits |
| fsync_i | input | 1 | Shared frame-sync pulse marking position 0 |
| tx_ch_i | input | 4 | Per-channel transmit bits |
| mux_tx_o | output | 1 | Combined transmit stream |
| mux_rx_i | input | 1 | Combined receive stream |
| rx_data_o | output | 4 | Last bit captured by each channel |
| rx_vld_o | output | 4 | Per-channel capture strobe |
| config_error_o | output | 1 | Illegal configuration flag |

## Verification
Frame-sync realignment and slot selection can land on the same cycle. Every slot decision then depends on whether the restart has already taken effect. The bench drives fsync_i at odd, mid-byte positions so that the restart and a slot boundary coincide. A cycle-by-cycle model then judges which channel owns that bit on both directions. A configuration change can also raise config_error_o on the same cycle as an active slot. The bench changes the index or rate between two bits and checks that the very next output is zero.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;
  typedef enum logic [1:0] {
    RATE_16M = 2'd0,
    RATE_8M  = 2'd1,
    RATE_12M = 2'd2,
    RATE_6M  = 2'd3
  } rate_e;

  // byte ordering needs a power-of-two aggregate rate
  function automatic logic byte_rate_ok(input logic [1:0] rate);
    return (rate == RATE_16M) || (rate == RATE_8M);
  endfunction
endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
  parameter int N_CH   = 4,
  parameter int BYTE_W = 8,
  localparam int POS_W = $clog2(N_CH * BYTE_W),
  localparam int SLT_W = $clog2(N_CH),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             byte_mode_i,
  output logic [SLT_W-1:0] slot_o
);
  logic [POS_W-1:0] pos_q, pos_cur;

  assign pos_cur = fsync_i ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '1;
    else         pos_q <= pos_cur;
  end

  always_comb begin
    if (byte_mode_i) slot_o = pos_cur[BIT_W +: SLT_W];
    else             slot_o = pos_cur[SLT_W-1:0];
  end
endmodule

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check #(
  parameter int N_CH  = 4,
  parameter int IDX_W = 3
) (
  input  logic                  byte_mode_i,
  input  logic [1:0]            rate_sel_i,
  input  logic [N_CH*IDX_W-1:0] phase_idx_i,
  output logic                  err_o
);
  import tdm_mux_pkg::*;
  localparam int N_PAIR = N_CH * (N_CH - 1) / 2;

  logic [N_PAIR-1:0] dup;

  for (genvar a = 0; a < N_CH; a++) begin : g_a
    for (genvar b = a + 1; b < N_CH; b++) begin : g_b
      localparam int K = a * N_CH - a * (a + 1) / 2 + (b - a - 1);
      assign dup[K] = phase_idx_i[a*IDX_W +: IDX_W] == phase_idx_i[b*IDX_W +: IDX_W];
    end
  end

  assign err_o = (byte_mode_i && !byte_rate_ok(rate_sel_i)) || (|dup);
endmodule

// File: rtl/tdm_slice.sv
module tdm_slice #(
  parameter int IDX_W = 3,
  parameter int SLT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SLT_W-1:0] slot_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tx_bit_i,
  input  logic             rx_bit_i,
  output logic             tx_gated_o,
  output logic             rx_bit_o,
  output logic             rx_vld_o
);
  logic act;

  assign act        = run_i && (idx_i == IDX_W'(slot_i));
  assign tx_gated_o = act && tx_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_bit_o <= 1'b0;
      rx_vld_o <= 1'b0;
    end else begin
      rx_vld_o <= act;
      if (act) rx_bit_o <= rx_bit_i;
    end
  end
endmodule

// File: rtl/tdm_quad_mux.sv
module tdm_quad_mux #(
  parameter int N_CH   = 4,
  parameter int IDX_W  = 3,
  parameter int BYTE_W = 8,
  parameter int EN_BIT = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [7:0]            cfg_i,
  input  logic [1:0]            rate_sel_i,
  input  logic                  byte_mode_i,
  input  logic [N_CH*IDX_W-1:0] phase_idx_i,
  input  logic                  fsync_i,
  input  logic [N_CH-1:0]       tx_ch_i,
  output logic                  mux_tx_o,
  input  logic                  mux_rx_i,
  output logic [N_CH-1:0]       rx_data_o,
  output logic [N_CH-1:0]       rx_vld_o,
  output logic                  config_error_o
);
  localparam int SLT_W = $clog2(N_CH);

  logic [SLT_W-1:0] slot;
  logic [N_CH-1:0]  tx_gated;
  logic             run;

  tdm_pos_counter #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_pos (
    .clk_i, .rst_ni, .fsync_i, .byte_mode_i, .slot_o(slot)
  );

  tdm_cfg_check #(.N_CH(N_CH), .IDX_W(IDX_W)) u_cfg (
    .byte_mode_i, .rate_sel_i, .phase_idx_i, .err_o(config_error_o)
  );

  assign run = cfg_i[EN_BIT] && !config_error_o;

  for (genvar c = 0; c < N_CH; c++) begin : g_slice
    tdm_slice #(.IDX_W(IDX_W), .SLT_W(SLT_W)) u_slice (
      .clk_i, .rst_ni,
      .run_i      (run),
      .slot_i     (slot),
      .idx_i      (phase_idx_i[c*IDX_W +: IDX_W]),
      .tx_bit_i   (tx_ch_i[c]),
      .rx_bit_i   (mux_rx_i),
      .tx_gated_o (tx_gated[c]),
      .rx_bit_o   (rx_data_o[c]),
      .rx_vld_o   (rx_vld_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mux_tx_o <= 1'b0;
    else         mux_tx_o <= |tx_gated;
  end
endmodule

// File: rtl/tdm_quad_mux_chk.sv
module tdm_quad_mux_chk #(
  parameter int N_CH  = 4,
  parameter int IDX_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [7:0]            cfg_i,
  input logic [1:0]            rate_sel_i,
  input logic                  byte_mode_i,
  input logic                  mux_tx_o,
  input logic [N_CH-1:0]       rx_data_o,
  input logic [N_CH-1:0]       rx_vld_o,
  input logic                  config_error_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!mux_tx_o && rx_vld_o == '0)); // R1
  AST_DIS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni) !cfg_i[7] |=> (!mux_tx_o && rx_vld_o == '0)); // R2
  AST_BYTE_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni) (byte_mode_i && rate_sel_i[1]) |-> config_error_o); // R8
  AST_VLD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(rx_vld_o)); // R6
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni) config_error_o |=> (!mux_tx_o && rx_vld_o == '0)); // R10
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (rx_vld_o == '0) |-> $stable(rx_data_o)); // R11
endmodule

bind tdm_quad_mux tdm_quad_mux_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .cfg_i, .rate_sel_i, .byte_mode_i,
  .mux_tx_o, .rx_data_o, .rx_vld_o, .config_error_o
);

// File: tb/tdm_quad_mux_tb.sv
module tdm_quad_mux_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_i = 8'h00;
  logic [1:0]  rate_sel_i = 2'd0;
  logic        byte_mode_i = 1'b0;
  logic [11:0] phase_idx_i = 12'h0;
  logic        fsync_i = 1'b0;
  logic [3:0]  tx_ch_i = 4'h0;
  logic        mux_rx_i = 1'b0;
  logic        mux_tx_o, config_error_o;
  logic [3:0]  rx_data_o, rx_vld_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  int   m_pos = 31;
  logic m_tx = 0;
  logic [3:0] m_rxd = 0, m_vld = 0;

  tdm_quad_mux u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic logic exp_err();
    int ix[4];
    for (int c = 0; c < 4; c++) ix[c] = phase_idx_i[c*3 +: 3];
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (ix[a] == ix[b]) return 1'b1;
    return byte_mode_i && (rate_sel_i >= 2);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pos = 31; m_tx = 0; m_rxd = 0; m_vld = 0;
    end else begin
      int ph;
      logic en_run;
      m_pos = fsync_i ? 0 : (m_pos + 1) % 32;
      ph = byte_mode_i ? (m_pos / 8) % 4 : m_pos % 4;
      en_run = cfg_i[7] && !exp_err();
      m_tx = 0; m_vld = 0;
      for (int c = 0; c < 4; c++)
        if (en_run && int'(phase_idx_i[c*3 +: 3]) == ph) begin
          m_tx = m_tx | tx_ch_i[c];
          m_vld[c] = 1'b1;
          m_rxd[c] = mux_rx_i;
        end
    end
  end

  task automatic chk(string t, string what, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    chk(tag, "mux_tx_o", {3'b0, mux_tx_o}, {3'b0, m_tx});
    chk(tag, "rx_vld_o", rx_vld_o, m_vld);
    chk(tag, "rx_data_o", rx_data_o, m_rxd);
    chk(tag, "config_error_o", {3'b0, config_error_o}, {3'b0, exp_err()});
  endtask

  // one cycle: compare at negedge, then drive fresh random data
  task automatic step(input logic sync);
    @(negedge clk_i);
    cmp_all();
    tx_ch_i  = 4'($urandom);
    mux_rx_i = 1'($urandom);
    fsync_i  = sync;
  endtask

  task automatic run(int n, int sync_at);
    for (int i = 0; i < n; i++) step(i == sync_at);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    cfg_i = 8'h80; phase_idx_i = {3'd3, 3'd2, 3'd1, 3'd0};
    tx_ch_i = 4'hF; mux_rx_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", "reset mux_tx_o", {3'b0, mux_tx_o}, 4'h0);
      chk("R1", "reset rx_vld_o", rx_vld_o, 4'h0);
      chk("R1", "reset rx_data_o", rx_data_o, 4'h0);
    end
    rst_ni = 1'b1;

    // R3/R4/R6/R11: bit interleave, identity slots, no sync first
    tag = "R4"; run(40, -1);
    tag = "R3"; run(50, 5);
    // R6: permuted slots, R11 receive
    tag = "R6"; phase_idx_i = {3'd1, 3'd3, 3'd0, 3'd2}; run(40, 0);
    tag = "R11"; run(40, 2);
    // R5: byte interleave at both legal rates, sync mid-byte
    tag = "R5"; byte_mode_i = 1; rate_sel_i = 2'd0; run(80, 3);
    rate_sel_i = 2'd1; run(80, 13);
    // R8: illegal byte rates, then bit mode at those rates is legal
    tag = "R8"; rate_sel_i = 2'd2; run(20, -1);
    @(negedge clk_i); chk("R8", "byte@12.352 error", {3'b0, config_error_o}, 4'h1);
    rate_sel_i = 2'd3; run(20, -1);
    byte_mode_i = 0; run(30, 1);
    chk("R8", "bit@6.176 no error", {3'b0, config_error_o}, 4'h0);
    // R9/R10: duplicate index, switched in between bits
    tag = "R9"; phase_idx_i = {3'd1, 3'd1, 3'd0, 3'd2}; run(20, -1);
    @(negedge clk_i); chk("R9", "duplicate error", {3'b0, config_error_o}, 4'h1);
    tag = "R10"; tx_ch_i = 4'hF; run(20, 4);
    phase_idx_i = {3'd3, 3'd2, 3'd1, 3'd0}; run(12, -1);
    // R7: codes 4..7 never match
    tag = "R7"; phase_idx_i = {3'd5, 3'd2, 3'd1, 3'd0}; run(40, 1);
    phase_idx_i = {3'd3, 3'd7, 3'd4, 3'd6}; run(30, -1);
    // R2: disable, other cfg bits ignored
    tag = "R2"; phase_idx_i = {3'd3, 3'd2, 3'd1, 3'd0};
    cfg_i = 8'h7F; run(40, 0);
    cfg_i = 8'hFF; run(40, 6);
    cfg_i = 8'h80; run(20, -1);
    // R3: sync every few cycles, pos restarts at odd points
    tag = "R3"; byte_mode_i = 1; rate_sel_i = 2'd0;
    for (int k = 0; k < 10; k++) run(11 + k, 7 + k % 3);
    // R1: asynchronous reset in mid stream
    tag = "R1";
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R1", "mid reset mux_tx_o", {3'b0, mux_tx_o}, 4'h0);
    chk("R1", "mid reset rx_vld_o", rx_vld_o, 4'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    run(40, -1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule